// File: doc/BRIEF.md
# Frame-Organized DRAM Buffer Arbiter

This block owns the single external DRAM that serves as the sector buffer of an optical-disc data path. Nine client ports compete for it: the front-end byte writer, the read and write sides of the error-correction engine, a 16-bit host DMA port, the microcontroller and four auxiliary ports. An internal refresh timer is a tenth requester. Each client names a location as a frame number plus a byte offset. The block turns that into a multiplexed row and column address, then drives the row strobe, column strobe, write enable and output enable itself.

Streaming clients keep the row open and step through columns in page mode for as long as they keep asking, stay inside the row, and no more urgent requester is waiting. The microcontroller gets no wait line. Its clock enable is pulled low while its access is outstanding, so the core freezes until its byte arrives.

Top module: `frame_dram_arbiter`

## Requirements
- R1: At most one client grant is high in any cycle, and a done pulse only ever appears on the port that holds the grant.
- R2: Fixed priority, most urgent first: refresh, then client ports 0 (front-end write), 1 (correction read), 2 (correction write), 3 (host DMA), 4 (microcontroller), 5 to 8 (auxiliary). Requests raised together are served in that order.
- R3: A byte at frame f, offset o lives at physical address p = f*3072 + o. In large mode (cfg_big=1) the row is p[19:10] and the column is p[9:0]. In small mode the row is p[17:9] and the column is p[8:0] on pins 8..0, with pin 9 low.
- R4: A frame number at or above the mode's frame count (341 large, 85 small), or an offset of 3072 or more, ends the request with one cycle of done and addr_err together and no DRAM strobe.
- R5: Ports 1, 2 and 3 are burst ports. A next address in the same row, with no more urgent request pending, keeps the row strobe low and issues only a new column cycle. A row change reopens the row.
- R6: Port 3 moves 16 bits per done. The low byte is at the even offset given and the high byte at the next offset.
- R7: cpu_ce is low while port 4 requests and has not yet received done. It is high in the done cycle and whenever port 4 is not requesting.
- R8: The row strobe stays high for at least 3 cycles between low periods. A column strobe follows the row strobe by at least 2 cycles.
- R9: A refresh with the column strobe falling before the row strobe is requested every 528 cycles. A pending refresh starts within 13 cycles.
- R10: done pulses for one cycle per completed byte or word, and cli_rdata holds the read data in that cycle. Byte reads return zero in bits 15..8.
- R11: In reset all strobes are high (inactive), no grant or done is asserted and cpu_ce is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_big | input | 1 | 1 selects the 1 Mbyte device, 0 the 256 kbyte device |
| cli_req | input | 9 | Request per client port |
| cli_frame | input | 81 | Frame number per port, 9 bits each |
| cli_off | input | 108 | Byte offset per port, 12 bits each |
| cli_we | input | 9 | Write (1) or read (0) per port |
| cli_wdata | input | 144 | Write data per port, 16 bits each |
| cli_gnt | output | 9 | One-hot grant |
| cli_done | output | 9 | Per-beat completion pulse |
| cli_rdata | output | 16 | Read data, valid with done |
| addr_err | output | 1 | Out-of-range request flag, pulses with done |
| cpu_ce | output | 1 | Microcontroller clock enable |
| dram_a | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dout | output | 8 | Byte written to the DRAM |
| dram_din | input | 8 | Byte read from the DRAM |

## Verification
The assertions assume that a client keeps its request, frame, offset, direction and data steady from the request until its done pulse, and changes them only in that done cycle. They also assume that cfg_big changes only while no access is in flight and that port 3 always gives even offsets. The bench drives every input on the falling clock edge and moves a client's address only when it sees that client's done. It switches cfg_big only after an access has finished and the precharge that follows has passed.

// File: rtl/bufarb_pkg.sv
package bufarb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_RAS, ST_CAS, ST_CHK, ST_PRE, ST_REF, ST_ERR
   } bst_t;
   localparam int unsigned FRAME_BYTES = 3072;
   localparam int unsigned FRAME_SHIFT = 10;   // FRAME_BYTES = 3 << FRAME_SHIFT
endpackage

// File: rtl/bufarb_prio.sv
module bufarb_prio #(
   parameter int N     = 9,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
      any = |req;
   end
endmodule

// File: rtl/bufarb_map.sv
module bufarb_map import bufarb_pkg::*; #(
   parameter int FRAME_W = 9,
   parameter int OFF_W   = 12,
   parameter int PIN_W   = 10
) (
   input  logic               big,
   input  logic [FRAME_W-1:0] frame,
   input  logic [OFF_W-1:0]   offset,
   output logic [PIN_W-1:0]   row,
   output logic [PIN_W-1:0]   col,
   output logic               bad
);
   localparam int PHW       = 2 * PIN_W;
   localparam int LIM_BIG   = (2 ** PHW) / FRAME_BYTES;
   localparam int LIM_SMALL = (2 ** (PHW - 2)) / FRAME_BYTES;

   if (FRAME_W < $clog2(LIM_BIG)) begin : g_frame_w_bad
      $error("FRAME_W too narrow for the large device frame count");
   end

   logic [PHW-1:0] base, phys;
   always_comb begin
      base = PHW'(frame) * PHW'(3);
      phys = (base << FRAME_SHIFT) + PHW'(offset);
      if (big) begin
         row = phys[PHW-1:PIN_W];
         col = phys[PIN_W-1:0];
      end else begin
         row = {1'b0, phys[PHW-3:PIN_W-1]};
         col = {1'b0, phys[PIN_W-2:0]};
      end
      bad = (offset >= OFF_W'(FRAME_BYTES)) ||
            (big ? (32'(frame) >= LIM_BIG) : (32'(frame) >= LIM_SMALL));
   end
endmodule

// File: rtl/bufarb_refresh.sv
module bufarb_refresh #(
   parameter int PERIOD = 528,
   parameter int CW     = $clog2(PERIOD)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pend
);
   logic [CW-1:0] cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         if (ack) pend <= 1'b0;
         if (cnt == CW'(PERIOD - 1)) begin
            cnt  <= '0;
            pend <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/frame_dram_arbiter.sv
module frame_dram_arbiter import bufarb_pkg::*; #(
   parameter int N_CLI      = 9,
   parameter int FRAME_W    = 9,
   parameter int OFF_W      = 12,
   parameter int PIN_W      = 10,
   parameter int BYTE_W     = 8,
   parameter int REF_PERIOD = 528,
   parameter int T_RP       = 3,
   parameter int T_RCD      = 2,
   parameter int T_CAS      = 2,
   parameter int T_CBR      = 3,
   parameter logic [N_CLI-1:0] BURST_MASK = N_CLI'('b1110),
   parameter logic [N_CLI-1:0] WIDE_MASK  = N_CLI'('b1000),
   parameter int MCU_IDX    = 4,
   localparam int WORD_W    = 2 * BYTE_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_big,
   input  logic [N_CLI-1:0]         cli_req,
   input  logic [N_CLI*FRAME_W-1:0] cli_frame,
   input  logic [N_CLI*OFF_W-1:0]   cli_off,
   input  logic [N_CLI-1:0]         cli_we,
   input  logic [N_CLI*WORD_W-1:0]  cli_wdata,
   output logic [N_CLI-1:0]         cli_gnt,
   output logic [N_CLI-1:0]         cli_done,
   output logic [WORD_W-1:0]        cli_rdata,
   output logic                     addr_err,
   output logic                     cpu_ce,
   output logic [PIN_W-1:0]         dram_a,
   output logic                     dram_ras_n,
   output logic                     dram_cas_n,
   output logic                     dram_we_n,
   output logic                     dram_oe_n,
   output logic [BYTE_W-1:0]        dram_dout,
   input  logic [BYTE_W-1:0]        dram_din
);
   localparam int IDX_W = $clog2(N_CLI);
   localparam int CNT_W = 3;

   if (T_CAS < 2 || T_RCD < 1 || T_RP < 1 || T_CBR < 1 ||
       T_CAS > 7 || T_RCD > 7 || T_RP > 7 || T_CBR > 7) begin : g_timing_bad
      $error("DRAM timing parameters out of range");
   end
   if (MCU_IDX >= N_CLI) begin : g_mcu_bad
      $error("MCU_IDX outside the client range");
   end

   bst_t               st;
   logic [CNT_W-1:0]   cnt;
   logic [IDX_W-1:0]   own, win, sel;
   logic               any_req, ref_pend, ref_ack;
   logic [PIN_W-1:0]   row_q, col_q, m_row, m_col;
   logic               m_bad, half, we_q;
   logic [WORD_W-1:0]  wdat_q, rd_q;
   logic [N_CLI-1:0]   above;
   logic               hp_pend, cont, beat_end, gnt_act, cas_lo, ras_lo;

   bufarb_prio #(.N(N_CLI)) u_prio (.req(cli_req), .idx(win), .any(any_req));

   assign sel = (st == ST_IDLE) ? win : own;

   bufarb_map #(.FRAME_W(FRAME_W), .OFF_W(OFF_W), .PIN_W(PIN_W)) u_map (
      .big   (cfg_big),
      .frame (cli_frame[sel*FRAME_W +: FRAME_W]),
      .offset(cli_off[sel*OFF_W +: OFF_W]),
      .row   (m_row),
      .col   (m_col),
      .bad   (m_bad)
   );

   bufarb_refresh #(.PERIOD(REF_PERIOD)) u_ref (
      .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend)
   );

   always_comb begin
      ref_ack  = (st == ST_IDLE) && ref_pend;
      above    = (N_CLI'(1) << own) - N_CLI'(1);
      hp_pend  = ref_pend || (|(cli_req & above));
      cont     = BURST_MASK[own] && cli_req[own] && !m_bad &&
                 (m_row == row_q) && !hp_pend;
      beat_end = (st == ST_CAS) && (cnt == CNT_W'(T_CAS - 1)) &&
                 (!WIDE_MASK[own] || half);
      gnt_act  = (st == ST_RAS) || (st == ST_CAS) || (st == ST_CHK) || (st == ST_ERR);
      cas_lo   = ((st == ST_CAS) && (cnt < CNT_W'(T_CAS - 1))) || (st == ST_REF);
      ras_lo   = (st == ST_RAS) || (st == ST_CAS) || (st == ST_CHK) ||
                 ((st == ST_REF) && (cnt != '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         own    <= '0;
         row_q  <= '0;
         col_q  <= '0;
         half   <= 1'b0;
         we_q   <= 1'b0;
         wdat_q <= '0;
         rd_q   <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               cnt <= '0;
               if (ref_pend) begin
                  st <= ST_REF;
               end else if (any_req) begin
                  own    <= win;
                  we_q   <= cli_we[win];
                  wdat_q <= cli_wdata[win*WORD_W +: WORD_W];
                  row_q  <= m_row;
                  col_q  <= m_col;
                  half   <= 1'b0;
                  rd_q   <= '0;
                  st     <= m_bad ? ST_ERR : ST_RAS;
               end
            end
            ST_RAS: begin
               if (cnt == CNT_W'(T_RCD - 1)) begin
                  st  <= ST_CAS;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_CAS: begin
               if (cnt == CNT_W'(T_CAS - 2) && !we_q)
                  rd_q[half*BYTE_W +: BYTE_W] <= dram_din;
               if (cnt == CNT_W'(T_CAS - 1)) begin
                  cnt <= '0;
                  if (WIDE_MASK[own] && !half) half <= 1'b1;
                  else st <= ST_CHK;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_CHK: begin
               cnt <= '0;
               if (cont) begin
                  st     <= ST_CAS;
                  col_q  <= m_col;
                  we_q   <= cli_we[own];
                  wdat_q <= cli_wdata[own*WORD_W +: WORD_W];
                  half   <= 1'b0;
                  rd_q   <= '0;
               end else begin
                  st <= ST_PRE;
               end
            end
            ST_PRE: begin
               if (cnt == CNT_W'(T_RP - 1)) begin
                  st  <= ST_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_REF: begin
               if (cnt == CNT_W'(T_CBR)) begin
                  st  <= ST_PRE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_ERR:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < N_CLI; g++) begin : g_port
      assign cli_gnt[g]  = gnt_act && (own == IDX_W'(g));
      assign cli_done[g] = (beat_end || st == ST_ERR) && (own == IDX_W'(g));
   end

   assign cli_rdata  = rd_q;
   assign addr_err   = (st == ST_ERR);
   assign cpu_ce     = !(cli_req[MCU_IDX] && !cli_done[MCU_IDX]);
   assign dram_a     = (st == ST_RAS) ? row_q : (col_q | PIN_W'(half));
   assign dram_ras_n = !ras_lo;
   assign dram_cas_n = !cas_lo;
   assign dram_we_n  = !((st == ST_CAS) && cas_lo && we_q);
   assign dram_oe_n  = !((st == ST_CAS) && cas_lo && !we_q);
   assign dram_dout  = half ? wdat_q[WORD_W-1:BYTE_W] : wdat_q[BYTE_W-1:0];
endmodule

// File: rtl/frame_dram_arbiter_chk.sv
module frame_dram_arbiter_chk #(
   parameter int N_CLI = 9,
   parameter int T_RP  = 3,
   parameter int T_RCD = 2,
   parameter int T_CAS = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_CLI-1:0] cli_gnt,
   input logic [N_CLI-1:0] cli_done,
   input logic             addr_err,
   input logic             dram_ras_n,
   input logic             dram_cas_n,
   input logic             ref_pend
);
   localparam int LAT_MAX = T_RCD + 2 * T_CAS + T_RP + 4;

   logic [7:0] hi_cnt, lo_cnt, wait_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt   <= 8'(T_RP);
         lo_cnt   <= '0;
         wait_cnt <= '0;
      end else begin
         hi_cnt   <= dram_ras_n ? ((hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 1'b1) : '0;
         lo_cnt   <= !dram_ras_n ? ((lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 1'b1) : '0;
         wait_cnt <= ref_pend ? ((wait_cnt == 8'hFF) ? wait_cnt : wait_cnt + 1'b1) : '0;
      end
   end

   a_r1_onehot_gnt: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cli_gnt));
   a_r1_done_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (cli_done & ~cli_gnt) == '0);
   a_r4_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> (dram_ras_n && dram_cas_n && (|cli_done)));
   a_r8_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (hi_cnt >= 8'(T_RP)));
   a_r8_ras_to_cas: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_cas_n) && !dram_ras_n) |-> (lo_cnt >= 8'(T_RCD)));
   a_r9_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_ras_n) && !dram_cas_n) |-> $past(!dram_cas_n));
   a_r9_ref_latency: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pend |-> (wait_cnt < 8'(LAT_MAX)));
endmodule

bind frame_dram_arbiter frame_dram_arbiter_chk #(
   .N_CLI(N_CLI), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cli_gnt(cli_gnt), .cli_done(cli_done),
   .addr_err(addr_err), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
   .ref_pend(ref_pend)
);

// File: tb/sim_frame_dram_arbiter.sv
module sim_frame_dram_arbiter;
   localparam int N = 9, FW = 9, OW = 12, PW = 10;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, cfg_big;
   logic [N-1:0]      req, we_r;
   logic [FW-1:0]     fr [N];
   logic [OW-1:0]     of [N];
   logic [15:0]       wd [N];
   logic [N*FW-1:0]   cli_frame;
   logic [N*OW-1:0]   cli_off;
   logic [N*16-1:0]   cli_wdata;
   logic [N-1:0]      gnt, done;
   logic [15:0]       rdata;
   logic              addr_err, cpu_ce, ras_n, cas_n, we_n, oe_n;
   logic [PW-1:0]     dram_a;
   logic [7:0]        dout, din;

   for (genvar g = 0; g < N; g++) begin : g_flat
      assign cli_frame[g*FW +: FW] = fr[g];
      assign cli_off[g*OW +: OW]   = of[g];
      assign cli_wdata[g*16 +: 16] = wd[g];
   end

   frame_dram_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .cfg_big(cfg_big), .cli_req(req),
      .cli_frame(cli_frame), .cli_off(cli_off), .cli_we(we_r), .cli_wdata(cli_wdata),
      .cli_gnt(gnt), .cli_done(done), .cli_rdata(rdata), .addr_err(addr_err),
      .cpu_ce(cpu_ce), .dram_a(dram_a), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
      .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_dout(dout), .dram_din(din)
   );

   int checks = 0, errors = 0;

   task automatic chk(string r, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
      end
   endtask

   // DRAM model and strobe bookkeeping
   bit [7:0] mem [int];
   bit [7:0] shadow [int];
   logic [PW-1:0] row_l;
   logic prev_ras = 1'b1;
   int ras_falls = 0, cbr_cnt = 0, hi_run = 0, min_gap = 1000;

   function automatic int maddr(logic [PW-1:0] r, logic [PW-1:0] c);
      return cfg_big ? int'({r, c}) : int'({r[8:0], c[8:0]});
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_ras && !ras_n) begin
            if (hi_run < min_gap) min_gap = hi_run;
            if (!cas_n) cbr_cnt++;
            else begin
               row_l = dram_a;
               ras_falls++;
            end
         end
         hi_run = ras_n ? hi_run + 1 : 0;
         if (!ras_n && !cas_n && !we_n) mem[maddr(row_l, dram_a)] = dout;
         if (!ras_n && !cas_n && !oe_n)
            din = mem.exists(maddr(row_l, dram_a)) ? mem[maddr(row_l, dram_a)] : 8'h00;
         prev_ras = ras_n;
      end
   end

   // Scoreboard
   logic [19:0] exp_q [$];
   always @(negedge clk) begin
      if (rst_n && !addr_err) begin
         for (int c = 0; c < N; c++) begin
            if (done[c] && !we_r[c]) begin
               if (exp_q.size() == 0) chk("R10", "unexpected read done", c, 99);
               else begin
                  logic [19:0] e;
                  e = exp_q.pop_front();
                  chk("R10", "read client", c, e[19:16]);
                  chk((c == 3) ? "R6" : "R10", "read data", rdata, e[15:0]);
               end
            end
         end
      end
   end

   function automatic bit [7:0] sh(int p);
      return shadow.exists(p) ? shadow[p] : 8'h00;
   endfunction

   function automatic logic [15:0] dat(int f, int o, int s);
      return {8'(o * 5 + s + 1), 8'(f * 3 + o + s)};
   endfunction

   task automatic note(int c, int f, int o, bit w, logic [15:0] d);
      int p = f * 3072 + o;
      if (w) begin
         shadow[p] = d[7:0];
         if (c == 3) shadow[p + 1] = d[15:8];
      end else begin
         exp_q.push_back({4'(c), (c == 3) ? {sh(p + 1), sh(p)} : {8'h00, sh(p)}});
      end
   endtask

   task automatic acc(int c, int f, int o, bit w, logic [15:0] d, bit exp_err);
      bit ce_bad = 0;
      @(negedge clk);
      if (!exp_err) note(c, f, o, w, d);
      req[c] = 1'b1; fr[c] = FW'(f); of[c] = OW'(o); we_r[c] = w; wd[c] = d;
      @(negedge clk);
      while (!done[c]) begin
         if (c == 4 && cpu_ce) ce_bad = 1;
         @(negedge clk);
      end
      if (c == 4) chk("R7", "clock enable held low then released", {ce_bad, cpu_ce}, 2'b01);
      if (exp_err || addr_err) chk("R4", "error flag", addr_err, exp_err);
      req[c] = 1'b0;
   endtask

   task automatic burst(int c, int f, int o0, int n, bit w, int s, output int falls);
      int step = (c == 3) ? 2 : 1;
      int f0;
      for (int k = 0; k < n; k++) note(c, f, o0 + k * step, w, dat(f, o0 + k * step, s));
      @(negedge clk);
      req[c] = 1'b1; fr[c] = FW'(f); of[c] = OW'(o0); we_r[c] = w; wd[c] = dat(f, o0, s);
      f0 = ras_falls;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         while (!done[c]) @(negedge clk);
         if (k == n - 1) req[c] = 1'b0;
         else begin
            of[c] = OW'(o0 + (k + 1) * step);
            wd[c] = dat(f, o0 + (k + 1) * step, s);
         end
      end
      falls = ras_falls - f0;
   endtask

   task automatic wait_ref();
      int c0 = cbr_cnt;
      while (cbr_cnt == c0) @(negedge clk);
      repeat (8) @(negedge clk);
   endtask

   // Watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int fl, c0, r0;
      time t0, t2, t4, t8;
      rst_n = 1'b0; cfg_big = 1'b1; req = '0; we_r = '0;
      for (int i = 0; i < N; i++) begin fr[i] = '0; of[i] = '0; wd[i] = '0; end
      repeat (5) @(negedge clk);
      chk("R11", "strobes idle in reset", {ras_n, cas_n, we_n, oe_n}, 4'hF);
      chk("R11", "grant and done in reset", {gnt, done}, 0);
      chk("R11", "cpu_ce in reset", cpu_ce, 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R3/R7: microcontroller writes in large mode, then reads back
      acc(4, 0, 0, 1, 16'h00A5, 0);
      acc(4, 340, 3071, 1, 16'h003C, 0);
      acc(4, 7, 1500, 1, 16'h0071, 0);
      acc(4, 200, 1023, 1, 16'h0012, 0);
      acc(4, 200, 1024, 1, 16'h0034, 0);
      chk("R3", "byte at frame 0 offset 0", mem[0], 8'hA5);
      chk("R3", "byte at frame 340 offset 3071", mem[340*3072+3071], 8'h3C);
      chk("R3", "byte at frame 7 offset 1500", mem[7*3072+1500], 8'h71);
      chk("R3", "bytes around a row edge", {mem[200*3072+1023], mem[200*3072+1024]}, 16'h1234);
      acc(4, 340, 3071, 0, 0, 0);
      acc(4, 200, 1024, 0, 0, 0);
      acc(4, 0, 0, 0, 0, 0);

      // R6: host DMA words
      wait_ref();
      burst(3, 5, 0, 4, 1, 3, fl);
      chk("R6", "word write low byte at even offset", mem[5*3072+2], dat(5, 2, 3) & 16'hFF);
      chk("R6", "word write high byte at next offset", mem[5*3072+3], dat(5, 2, 3) >> 8);
      wait_ref();
      burst(3, 5, 0, 4, 0, 0, fl);
      chk("R5", "word burst stays in one row", fl, 1);

      // R5: front-end fills, correction engine streams
      for (int k = 0; k < 8; k++) acc(0, 10, 100 + k, 1, dat(10, 100 + k, 9), 0);
      wait_ref();
      burst(1, 10, 100, 8, 0, 0, fl);
      chk("R5", "read burst uses one row opening", fl, 1);
      wait_ref();
      burst(2, 10, 100, 4, 1, 21, fl);
      chk("R5", "correction write burst uses one row opening", fl, 1);
      acc(4, 10, 101, 0, 0, 0);
      acc(4, 10, 104, 0, 0, 0);
      for (int k = 0; k < 4; k++) acc(0, 10, 1022 + k, 1, dat(10, 1022 + k, 2), 0);
      wait_ref();
      burst(1, 10, 1022, 4, 0, 0, fl);
      chk("R5", "row change reopens the row", fl, 2);

      // R2: simultaneous requests
      wait_ref();
      fork
         begin acc(8, 20, 8, 1, 16'h0088, 0); t8 = $time; end
         begin acc(4, 20, 4, 1, 16'h0044, 0); t4 = $time; end
         begin acc(2, 20, 2, 1, 16'h0022, 0); t2 = $time; end
         begin acc(0, 20, 0, 1, 16'h0011, 0); t0 = $time; end
      join
      chk("R2", "service order 0,2,4,8", (t0 < t2) && (t2 < t4) && (t4 < t8), 1);
      acc(5, 20, 8, 0, 0, 0);

      // R4: frame limits in both modes
      r0 = ras_falls;
      acc(4, 341, 0, 1, 16'h0055, 1);
      acc(6, 0, 3072, 0, 0, 1);
      chk("R4", "no row opening on rejected requests", ras_falls - r0, 0);
      repeat (6) @(negedge clk);
      cfg_big = 1'b0;
      repeat (2) @(negedge clk);
      acc(4, 84, 3071, 1, 16'h00E7, 0);
      chk("R3", "small mode last byte placement", mem[84*3072+3071], 8'hE7);
      r0 = ras_falls;
      acc(4, 85, 0, 1, 16'h0066, 1);
      acc(7, 100, 10, 0, 0, 1);
      chk("R4", "small mode rejects frame 85 without strobes", ras_falls - r0, 0);
      acc(4, 84, 3071, 0, 0, 0);

      // R9/R8: refresh cadence and precharge
      repeat (10) @(negedge clk);
      c0 = cbr_cnt;
      repeat (5280) @(negedge clk);
      chk("R9", "refresh count in 5280 cycles within 9..11",
          (cbr_cnt - c0 >= 9) && (cbr_cnt - c0 <= 11), 1);
      chk("R8", "shortest row precharge at least 3", min_gap >= 3, 1);
      chk("R10", "all expected reads returned", exp_q.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule